// File: doc/BRIEF.md
# Inter-processor interrupt mailbox

This block lets any processor in a system of `N_CPU` processors post a numbered inter-processor interrupt to its peers through a small register window. One write can deliver a number to a single named processor. Another write can broadcast the number to every processor except a named one. Each processor has its own first-in first-out queue of pending interrupt numbers and its own interrupt line. The line stays high while that queue holds anything.

A processor services its interrupts by reading the shared acknowledge register. The requester ID on the bus picks the queue, so the same address serves every processor. Each read returns the oldest number and pops it. A write to the same address discards everything pending for the requester. The queue depth is a parameter. A delivery that finds its queue full is dropped and latches a sticky per-processor overflow bit, which software can read.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every queue is empty, every bit of `irq_o` is 0, every overflow bit is 0, and an acknowledge read returns 0 for every requester.
- R2: A write to offset 0x00 with target ID T in wdata[15:0] and number V in wdata[31:16] appends V to the queue of processor T only. `irq_o[T]` is 1 from the cycle after that write.
- R3: A write to offset 0x08 appends V to the queue of every processor whose index differs from wdata[15:0], and raises their lines. It leaves processor T's queue unchanged.
- R4: A target ID of `N_CPU` or above matches no processor on offset 0x00, so nothing changes. On offset 0x08 it excludes no processor, so all processors receive V.
- R5: A read of offset 0x10 returns in rdata[15:0] the oldest pending number of the requesting processor, with the upper bits 0, and removes it. Numbers leave in the order they arrived.
- R6: A read of offset 0x10 by a processor with an empty queue returns 0 and changes nothing. Number 0 is therefore reserved.
- R7: A write to offset 0x10 discards all pending numbers of the requesting processor. The other queues are unchanged.
- R8: After an acknowledge access, the requester's line goes to 0 exactly when its queue has become empty. Otherwise it stays at 1.
- R9: A delivery to a queue that already holds `DEPTH` entries is dropped and sets overflow bit i. The queue keeps its earlier entries. The overflow bits read back in rdata[N_CPU-1:0] at offset 0x18, stay set until reset, and are not cleared by acknowledge or flush accesses.
- R10: Acknowledge accesses act only on the queue selected by `req_id_i`. The lines and queues of other processors do not change.
- R11: A read of a send offset returns 0. An access to any unmapped offset returns 0 on a read and changes no queue and no line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| req_id_i | input | ID_W | Index of the processor making the access |
| wdata_i | input | DATA_W | Write data: [15:0] target ID, [31:16] interrupt number |
| rdata_o | output | DATA_W | Read data, valid in the cycle of the access |
| irq_o | output | N_CPU | Per-processor interrupt line, 1 while its queue is non-empty |

## Verification
The hardest state to reach is a full queue that then receives one more delivery. The sticky bit must be set, the earlier contents must survive intact, and the pop order afterwards must be correct. The stimulus first drains the queues to a known level. It then sends single-target writes to one processor until its queue holds `DEPTH` entries, sends one more, and reads the overflow register. After that it pops the whole queue and checks every value, including the final 0. Broadcasts with an excluded target ID and with an out-of-range target ID are mixed in beforehand, so each queue holds a different history when it is drained.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned OFS_SEND_ONE  = 'h00;
  localparam int unsigned OFS_SEND_MANY = 'h08;
  localparam int unsigned OFS_ACK       = 'h10;
  localparam int unsigned OFS_OVF       = 'h18;
  localparam int unsigned TGT_W         = 16;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SEND_ONE,
    OP_SEND_MANY,
    OP_ACK_RD,
    OP_FLUSH,
    OP_OVF_RD
  } ipi_op_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ID_W   = 2
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [ID_W-1:0]   req_id_i,
  output ipi_op_e           op_o,
  output logic [N_CPU-1:0]  push_o,
  output logic [N_CPU-1:0]  pop_o,
  output logic [N_CPU-1:0]  flush_o
);
  localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(OFS_SEND_ONE);
  localparam logic [ADDR_W-1:0] A_MANY = ADDR_W'(OFS_SEND_MANY);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_OVF  = ADDR_W'(OFS_OVF);

  always_comb begin
    op_o = OP_NONE;
    if (sel_i) begin
      unique case (addr_i)
        A_ONE:   op_o = we_i ? OP_SEND_ONE  : OP_NONE;
        A_MANY:  op_o = we_i ? OP_SEND_MANY : OP_NONE;
        A_ACK:   op_o = we_i ? OP_FLUSH     : OP_ACK_RD;
        A_OVF:   op_o = we_i ? OP_NONE      : OP_OVF_RD;
        default: op_o = OP_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_mask
    logic tgt_hit, req_hit;
    assign tgt_hit    = (tgt_i == TGT_W'(i));
    assign req_hit    = (req_id_i == ID_W'(i));
    // an out-of-range target hits no index: none for one, all for many
    assign push_o[i]  = ((op_o == OP_SEND_ONE) && tgt_hit) ||
                        ((op_o == OP_SEND_MANY) && !tgt_hit);
    assign pop_o[i]   = (op_o == OP_ACK_RD) && req_hit;
    assign flush_o[i] = (op_o == OP_FLUSH) && req_hit;
  end
endmodule

// File: rtl/ipi_queue.sv
module ipi_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned NUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [NUM_W-1:0] head_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [NUM_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, push_ok, pop_ok;

  assign full    = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (push_i && full) ovf_o <= 1'b1;
      if (flush_i) begin
        rd_q  <= '0;
        wr_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (push_ok) wr_q <= nxt(wr_q);
        if (pop_ok)  rd_q <= nxt(rd_q);
        if (push_ok && !pop_ok)      cnt_q <= cnt_q + CNT_W'(1);
        else if (pop_ok && !push_ok) cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_ok && !flush_i && (wr_q == PTR_W'(e))) mem_q[e] <= num_i;
    end
  end
endmodule

// File: rtl/ipi_rdmux.sv
module ipi_rdmux
  import ipi_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned NUM_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 2
) (
  input  ipi_op_e                       op_i,
  input  logic [ID_W-1:0]               req_id_i,
  input  logic [N_CPU-1:0][NUM_W-1:0]   head_i,
  input  logic [N_CPU-1:0]              empty_i,
  input  logic [N_CPU-1:0]              ovf_i,
  output logic [DATA_W-1:0]             rdata_o
);
  logic             req_ok;
  logic [NUM_W-1:0] head_sel;
  logic             empty_sel;

  assign req_ok = (32'(req_id_i) < N_CPU);

  always_comb begin
    head_sel  = '0;
    empty_sel = 1'b1;
    for (int i = 0; i < N_CPU; i++) begin
      if (req_ok && (req_id_i == ID_W'(i))) begin
        head_sel  = head_i[i];
        empty_sel = empty_i[i];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (op_i)
      OP_ACK_RD: if (!empty_sel) rdata_o = DATA_W'(head_sel);
      OP_OVF_RD: rdata_o = DATA_W'(ovf_i);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CPU-1:0]  irq_o
);
  localparam int unsigned NUM_W = DATA_W - TGT_W;

  ipi_op_e                     op;
  logic [N_CPU-1:0]            push, pop, flush, empty, ovf_q;
  logic [N_CPU-1:0][NUM_W-1:0] head;

  ipi_decode #(.N_CPU(N_CPU), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_decode (
    .sel_i    (sel_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .tgt_i    (wdata_i[TGT_W-1:0]),
    .req_id_i (req_id_i),
    .op_o     (op),
    .push_o   (push),
    .pop_o    (pop),
    .flush_o  (flush)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    ipi_queue #(.DEPTH(DEPTH), .NUM_W(NUM_W)) u_queue (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[i]),
      .num_i   (wdata_i[DATA_W-1:TGT_W]),
      .pop_i   (pop[i]),
      .flush_i (flush[i]),
      .head_o  (head[i]),
      .empty_o (empty[i]),
      .ovf_o   (ovf_q[i])
    );
    assign irq_o[i] = !empty[i];
  end

  ipi_rdmux #(.N_CPU(N_CPU), .NUM_W(NUM_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_rdmux (
    .op_i     (op),
    .req_id_i (req_id_i),
    .head_i   (head),
    .empty_i  (empty),
    .ovf_i    (ovf_q),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk
  import ipi_pkg::*;
#(
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ID_W-1:0]   req_id_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_CPU-1:0]  irq_o,
  input logic [N_CPU-1:0]  ovf_i
);
  logic wr_one, wr_many, rd_ack, wr_ack, unmapped;
  assign wr_one   = sel_i && we_i && (addr_i == ADDR_W'(OFS_SEND_ONE));
  assign wr_many  = sel_i && we_i && (addr_i == ADDR_W'(OFS_SEND_MANY));
  assign rd_ack   = sel_i && !we_i && (addr_i == ADDR_W'(OFS_ACK));
  assign wr_ack   = sel_i && we_i && (addr_i == ADDR_W'(OFS_ACK));
  assign unmapped = sel_i && (addr_i != ADDR_W'(OFS_SEND_ONE)) &&
                    (addr_i != ADDR_W'(OFS_SEND_MANY)) && (addr_i != ADDR_W'(OFS_ACK)) &&
                    (addr_i != ADDR_W'(OFS_OVF));

  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i || unmapped) |=> $stable(irq_o));

  a_r11_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unmapped && !we_i) |-> (rdata_o == '0));

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    a_r2_send_one_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_one && (wdata_i[TGT_W-1:0] == TGT_W'(i))) |=> irq_o[i]);

    a_r3_send_many_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_many && (wdata_i[TGT_W-1:0] != TGT_W'(i))) |=> irq_o[i]);

    a_r6_empty_ack_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ack && (req_id_i == ID_W'(i)) && !irq_o[i]) |-> (rdata_o == '0));

    a_r7_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ack && (req_id_i == ID_W'(i))) |=> !irq_o[i]);

    a_r10_other_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rd_ack || wr_ack) && (req_id_i != ID_W'(i))) |=> $stable(irq_o[i]));

    a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[i] |=> ovf_i[i]);
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(
  .N_CPU(N_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .req_id_i (req_id_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .ovf_i    (ovf_q)
);

// File: tb/ipi_mailbox_bench.sv
`timescale 1ns/1ps
module ipi_mailbox_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  req_id_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ipi_mailbox u_ipi_mailbox (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .req_id_i, .wdata_i, .rdata_o, .irq_o
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [1:0]  req;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [3:0]  irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TAB [NV] = '{
    '{1'b1, 8'h00, 2'd0, 32'h0005_0001, 32'h0,  4'b0010}, // R2 one -> cpu1
    '{1'b1, 8'h00, 2'd0, 32'h0007_0001, 32'h0,  4'b0010}, // R2
    '{1'b1, 8'h08, 2'd0, 32'h0009_0002, 32'h0,  4'b1011}, // R3 all but cpu2
    '{1'b0, 8'h10, 2'd1, 32'h0,         32'h5,  4'b1011}, // R5 oldest of cpu1
    '{1'b0, 8'h10, 2'd2, 32'h0,         32'h0,  4'b1011}, // R6 empty
    '{1'b0, 8'h10, 2'd0, 32'h0,         32'h9,  4'b1010}, // R8 cpu0 drains
    '{1'b1, 8'h00, 2'd0, 32'h0003_0004, 32'h0,  4'b1010}, // R4 id>=N, one
    '{1'b1, 8'h08, 2'd0, 32'h0011_ffff, 32'h0,  4'b1111}, // R4 id>=N, many
    '{1'b1, 8'h10, 2'd1, 32'h0,         32'h0,  4'b1101}, // R7 flush cpu1
    '{1'b0, 8'h10, 2'd1, 32'h0,         32'h0,  4'b1101}, // R7 flushed empty
    '{1'b0, 8'h10, 2'd3, 32'h0,         32'h9,  4'b1101}, // R5 R10
    '{1'b0, 8'h10, 2'd3, 32'h0,         32'h11, 4'b0101}, // R5 R8
    '{1'b0, 8'h00, 2'd2, 32'h0,         32'h0,  4'b0101}, // R11 read send reg
    '{1'b1, 8'h20, 2'd2, 32'h0001_0002, 32'h0,  4'b0101}, // R11 unmapped write
    '{1'b0, 8'h18, 2'd0, 32'h0,         32'h0,  4'b0101}  // R9 no overflow yet
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [1:0] r,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = we; addr_i = a; req_id_i = r; wdata_i = wd;
    #1 rd = rdata_o;
    @(posedge clk_i);
    #1 sel_i = 1'b0; we_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(posedge clk_i);
    #1 check("R1 irq after reset", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    for (int c = 0; c < 4; c++) begin
      access(1'b0, 8'h10, 2'(c), 32'h0, rd);
      check("R1 empty ack read", rd, 32'h0);
    end
    access(1'b0, 8'h18, 2'd0, 32'h0, rd);
    check("R1 overflow clear", rd, 32'h0);

    for (int v = 0; v < NV; v++) begin
      access(TAB[v].we, TAB[v].addr, TAB[v].req, TAB[v].wd, rd);
      check($sformatf("R2-table row %0d rdata", v), rd, TAB[v].rd);
      check($sformatf("R8-table row %0d irq", v), 32'(irq_o), 32'(TAB[v].irq));
    end

    // R9: cpu0 queue fill to DEPTH=4, one dropped
    for (int k = 0; k < 3; k++) access(1'b1, 8'h00, 2'd1, {16'(32'h21 + k), 16'd0}, rd);
    access(1'b0, 8'h18, 2'd0, 32'h0, rd);
    check("R9 no overflow at exactly full", rd, 32'h0);
    access(1'b1, 8'h00, 2'd1, 32'h0024_0000, rd);
    access(1'b0, 8'h18, 2'd0, 32'h0, rd);
    check("R9 overflow bit 0", rd, 32'h1);
    access(1'b0, 8'h10, 2'd0, 32'h0, rd);
    check("R9 kept oldest", rd, 32'h11);
    for (int k = 0; k < 3; k++) begin
      access(1'b0, 8'h10, 2'd0, 32'h0, rd);
      check("R5 fifo order after full", rd, 32'h21 + k);
    end
    check("R8 cpu0 line low after drain", 32'(irq_o[0]), 32'h0);
    access(1'b0, 8'h10, 2'd0, 32'h0, rd);
    check("R9 dropped value absent", rd, 32'h0);
    access(1'b1, 8'h10, 2'd0, 32'h0, rd);
    access(1'b0, 8'h18, 2'd0, 32'h0, rd);
    check("R9 overflow sticky after flush", rd, 32'h1);
    check("R10 cpu2 still pending", 32'(irq_o), 32'b0100);

    // R1: reset mid-run
    @(negedge clk_i) rst_ni = 1'b0;
    #1 check("R1 irq cleared by reset", 32'(irq_o), 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    access(1'b0, 8'h10, 2'd2, 32'h0, rd);
    check("R1 queue emptied by reset", rd, 32'h0);
    access(1'b0, 8'h18, 2'd0, 32'h0, rd);
    check("R1 overflow cleared by reset", rd, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule